// File: doc/BRIEF.md
# TLB Entry Write and Probe Controller

This block is the control-register side of a software-managed translation lookaside buffer. It holds five registers that software loads over a simple register bus: an entry high word (virtual page pair and address-space identifier), two entry low words (one per page of the pair), a page mask and an index. Two single-cycle commands act on them. A write command builds a TLB entry from the current register contents and stores it in the slot named by the index register. A probe command scans the stored entries one per cycle and reports the first one that matches the entry high word.

The register values are cleaned up as they enter the block. The page mask drops the bits that would select pages smaller than 4 KB. A written entry's virtual page number is aligned to an 8 KB page pair. The entry's global flag is the AND of the two low words' global bits. During a probe, each entry is compared under its own page mask, so large pages match across all of the address bits their mask covers.

The controller is a four-state machine. `ST_IDLE` waits for a command. `ST_COMMIT` stores an entry. `ST_SCAN` walks the entries. `ST_DONE` signals that a probe has finished. The transitions are:
- `ST_IDLE` to `ST_COMMIT` on a write command.
- `ST_IDLE` to `ST_SCAN` on a probe command.
- `ST_COMMIT` to `ST_IDLE` unconditionally.
- `ST_SCAN` to `ST_DONE` on a match or after the last entry.
- `ST_DONE` to `ST_IDLE` unconditionally.

An entry observation port lets a neighbouring translation path read any stored entry.

Top module: `tlb_wp_ctrl`

## Requirements
- R1: After reset, every register reads zero, every stored entry reads zero, and `busy` and `done` are low.
- R2: The register select codes are 0 = index, 1 = low word 0, 2 = low word 1, 3 = page mask and 4 = high word. Any other code reads zero. A bus write to the page mask keeps only bits 28..13 (write value AND 0x1FFFE000).
- R3: A bus write to a low word keeps bits 29..0. A bus write to the high word keeps bits 31..13 and 7..0. A bus write to the index keeps bits 5..0 and clears the not-found flag in bit 31. The index reads back as {not-found, 25 zeros, field[5:0]}.
- R4: A write command stores an entry in the slot given by the index field. The stored entry has VPN = high word with bits 12..0 cleared, ASID = high word bits 7..0, and mask = page mask. It is visible on the observation port after the second rising edge following the command edge. The observation port shows the high word as VPN | ASID.
- R5: The stored global flag is low word 0 bit 0 AND low word 1 bit 0. Each half keeps bits 29..1 of its own low word (PFN 29..6, cache attribute 5..3, dirty 2, valid 1). The observation port shows each half as {2'b00, bits 29..1, global}.
- R6: A write command whose index field is 12 or more (NUM_ENTRIES or above) changes no entry.
- R7: An entry matches a probe when two conditions hold. First, the high word AND NOT(mask | 0x1FFF) equals the entry VPN AND NOT(mask | 0x1FFF). Second, the entry's global flag is set or its ASID equals high word bits 7..0.
- R8: A probe that matches loads the lowest matching slot number into the index field and clears bit 31.
- R9: A probe with no match sets index bit 31 and leaves the index field unchanged.
- R10: A probe examines one entry per cycle. `done` is a one-cycle pulse that is high after m+1 rising edges following the command edge for a match in slot m, or after NUM_ENTRIES edges for a miss.
- R11: `busy` is high from the edge that accepts a command until the controller returns to idle. While `busy` is high, commands and register bus writes are ignored.
- R12: When a write command and a probe command arrive in the same idle cycle, only the write is performed and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register bus write strobe |
| reg_wsel | input | 3 | Register select for writes |
| reg_wdata | input | 32 | Register bus write data |
| reg_rsel | input | 3 | Register select for reads |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_write | input | 1 | Store entry at index |
| cmd_probe | input | 1 | Search entries for high word |
| busy | output | 1 | Controller not idle |
| done | output | 1 | Probe finished pulse |
| ent_sel | input | 6 | Slot to observe |
| ent_hi | output | 32 | Observed VPN and ASID |
| ent_mask | output | 32 | Observed page mask |
| ent_lo0 | output | 32 | Observed even-page half |
| ent_lo1 | output | 32 | Observed odd-page half |

## Verification
A scan pointer that skips or repeats a slot changes two things at the ports: the index loaded by the probe, and the number of edges before `done`. Both show up on the very probe that hits the damaged slot. A wrong sanitising mask or a wrong global combination is visible on the observation port two edges after the write command. It also changes which entry a later probe selects. A controller that does not honour `busy` corrupts the high word or an entry. That damage is visible as soon as the probe in flight finishes and the registers are read back.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;

    localparam int DW       = 32;
    localparam int PAGE_LSB = 13;
    localparam int MASK_MSB = 28;
    localparam int ASID_W   = 8;
    localparam int PFN_W    = 24;
    localparam int C_W      = 3;
    localparam int LO_MSB   = 29;

    localparam logic [DW-1:0] LOW_MASK   = (32'h1 << PAGE_LSB) - 32'h1;
    localparam logic [DW-1:0] PMASK_KEEP = ((32'h1 << (MASK_MSB + 1)) - 32'h1) & ~LOW_MASK;
    localparam logic [DW-1:0] LO_KEEP    = (32'h1 << (LO_MSB + 1)) - 32'h1;
    localparam logic [DW-1:0] HI_KEEP    = ~LOW_MASK | ((32'h1 << ASID_W) - 32'h1);

    typedef enum logic [2:0] {
        SEL_INDEX = 3'd0,
        SEL_LO0   = 3'd1,
        SEL_LO1   = 3'd2,
        SEL_PMASK = 3'd3,
        SEL_HI    = 3'd4
    } csel_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [C_W-1:0]   cattr;
        logic             dirty;
        logic             valid;
    } half_t;

    typedef struct packed {
        logic [DW-1:0]     vpn;
        logic [ASID_W-1:0] asid;
        logic [DW-1:0]     mask;
        logic              glob;
        half_t             h0;
        half_t             h1;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SCAN   = 2'd2,
        ST_DONE   = 2'd3
    } state_e;

endpackage

// File: rtl/tlbc_regs.sv
module tlbc_regs
    import tlbc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [2:0]       bus_sel,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             busy,
    input  logic             probe_ld,
    input  logic             probe_hit,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic [2:0]       rsel,
    output logic [DW-1:0]    rdata,
    output logic [DW-1:0]    hi_q,
    output logic [DW-1:0]    lo0_q,
    output logic [DW-1:0]    lo1_q,
    output logic [DW-1:0]    mask_q,
    output logic [IDX_W-1:0] idx_q
);

    localparam int PAD_W = DW - 1 - IDX_W;

    logic  miss_q;
    logic  bus_ok;
    csel_e wsel;
    csel_e rsel_e;

    assign bus_ok = bus_we && !busy;
    assign wsel   = csel_e'(bus_sel);
    assign rsel_e = csel_e'(rsel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo0_q  <= '0;
            lo1_q  <= '0;
            mask_q <= '0;
        end else if (bus_ok) begin
            if (wsel == SEL_HI)    hi_q   <= bus_wdata & HI_KEEP;
            if (wsel == SEL_LO0)   lo0_q  <= bus_wdata & LO_KEEP;
            if (wsel == SEL_LO1)   lo1_q  <= bus_wdata & LO_KEEP;
            if (wsel == SEL_PMASK) mask_q <= bus_wdata & PMASK_KEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            miss_q <= 1'b0;
        end else if (probe_ld) begin
            miss_q <= !probe_hit;
            if (probe_hit) idx_q <= probe_idx;
        end else if (bus_ok && wsel == SEL_INDEX) begin
            idx_q  <= bus_wdata[IDX_W-1:0];
            miss_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rsel_e)
            SEL_INDEX: rdata = {miss_q, {PAD_W{1'b0}}, idx_q};
            SEL_LO0:   rdata = lo0_q;
            SEL_LO1:   rdata = lo1_q;
            SEL_PMASK: rdata = mask_q;
            SEL_HI:    rdata = hi_q;
            default:   rdata = '0;
        endcase
    end

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && busy) |=> ($stable(hi_q) && $stable(lo0_q) && $stable(lo1_q) && $stable(mask_q)));

    // R2
    pmask_sanitize_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ok && wsel == SEL_PMASK) |=> ((mask_q & ~PMASK_KEEP) == '0));

    // R9
    miss_keeps_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_ld && !probe_hit) |=> (miss_q && $stable(idx_q)));

endmodule

// File: rtl/tlbc_store.sv
module tlbc_store
    import tlbc_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  entry_t           wentry,
    input  logic [IDX_W-1:0] scan_idx,
    input  logic [IDX_W-1:0] obs_idx,
    output entry_t           scan_entry,
    output entry_t           obs_entry
);

    entry_t ent_q [NUM_ENTRIES];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        entry_t slot_q;
        logic   slot_we;

        assign slot_we = we && (widx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slot_q <= '0;
            else if (slot_we) slot_q <= wentry;
        end

        assign ent_q[g] = slot_q;
    end

    always_comb begin
        scan_entry = '0;
        obs_entry  = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (scan_idx == IDX_W'(i)) scan_entry = ent_q[i];
            if (obs_idx == IDX_W'(i))  obs_entry  = ent_q[i];
        end
    end

    // R6
    widx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(widx) < NUM_ENTRIES));

    // R4
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ent_q[$past(widx)] == $past(wentry)));

endmodule

// File: rtl/tlbc_match.sv
module tlbc_match
    import tlbc_pkg::*;
(
    input  entry_t        ent,
    input  logic [DW-1:0] key_hi,
    output logic          hit
);

    logic [DW-1:0] eff_mask;
    logic          vpn_eq;
    logic          asid_ok;

    assign eff_mask = ent.mask | LOW_MASK;
    assign vpn_eq   = (key_hi & ~eff_mask) == (ent.vpn & ~eff_mask);
    assign asid_ok  = ent.glob || (ent.asid == key_hi[ASID_W-1:0]);
    assign hit      = vpn_eq && asid_ok;

endmodule

// File: rtl/tlb_wp_ctrl.sv
module tlb_wp_ctrl
    import tlbc_pkg::*;
#(
    parameter int NUM_ENTRIES = 12,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_wsel,
    input  logic [31:0]      reg_wdata,
    input  logic [2:0]       reg_rsel,
    output logic [31:0]      reg_rdata,
    input  logic             cmd_write,
    input  logic             cmd_probe,
    output logic             busy,
    output logic             done,
    input  logic [IDX_W-1:0] ent_sel,
    output logic [31:0]      ent_hi,
    output logic [31:0]      ent_mask,
    output logic [31:0]      ent_lo0,
    output logic [31:0]      ent_lo1
);

    localparam int PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_ENTRIES - 1);

    state_e            state_q, state_d;
    logic [PTR_W-1:0]  ptr_q;
    logic [DW-1:0]     hi_q, lo0_q, lo1_q, mask_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  scan_idx;
    entry_t            wentry, scan_entry, obs_entry;
    logic              hit, last, idx_ok;
    logic              store_we, probe_ld;

    // register file
    tlbc_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (reg_we),
        .bus_sel   (reg_wsel),
        .bus_wdata (reg_wdata),
        .busy      (busy),
        .probe_ld  (probe_ld),
        .probe_hit (hit),
        .probe_idx (scan_idx),
        .rsel      (reg_rsel),
        .rdata     (reg_rdata),
        .hi_q      (hi_q),
        .lo0_q     (lo0_q),
        .lo1_q     (lo1_q),
        .mask_q    (mask_q),
        .idx_q     (idx_q)
    );

    // entry assembled from the registers
    always_comb begin
        wentry          = '0;
        wentry.vpn      = hi_q & ~LOW_MASK;
        wentry.asid     = hi_q[ASID_W-1:0];
        wentry.mask     = mask_q;
        wentry.glob     = lo0_q[0] & lo1_q[0];
        wentry.h0       = half_t'(lo0_q[LO_MSB:1]);
        wentry.h1       = half_t'(lo1_q[LO_MSB:1]);
    end

    assign idx_ok   = int'(idx_q) < NUM_ENTRIES;
    assign scan_idx = IDX_W'(ptr_q);

    tlbc_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (store_we),
        .widx       (idx_q),
        .wentry     (wentry),
        .scan_idx   (scan_idx),
        .obs_idx    (ent_sel),
        .scan_entry (scan_entry),
        .obs_entry  (obs_entry)
    );

    tlbc_match u_match (
        .ent    (scan_entry),
        .key_hi (hi_q),
        .hit    (hit)
    );

    assign last = (ptr_q == LAST_PTR);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_write)      state_d = ST_COMMIT;
                else if (cmd_probe) state_d = ST_SCAN;
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_SCAN:   if (hit || last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and scan pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SCAN)  ptr_q <= '0;
            else if (!hit && !last)  ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        store_we = 1'b0;
        probe_ld = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_COMMIT: store_we = idx_ok;
            ST_SCAN:   probe_ld = hit || last;
            ST_DONE:   done = 1'b1;
            default:   busy = 1'b1;
        endcase
    end

    assign ent_hi   = obs_entry.vpn | DW'(obs_entry.asid);
    assign ent_mask = obs_entry.mask;
    assign ent_lo0  = {2'b00, obs_entry.h0, obs_entry.glob};
    assign ent_lo1  = {2'b00, obs_entry.h1, obs_entry.glob};

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (int'(ptr_q) < NUM_ENTRIES));

    // R12
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_write && cmd_probe) |=> (busy && !done) ##1 (!busy && !done));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_write && state_q != ST_DONE) |=> (state_q != ST_COMMIT));

endmodule

// File: tb/test_tlb_wp_ctrl.sv
module test_tlb_wp_ctrl;

    localparam int N  = 12;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_wsel = '0;
    logic [31:0]   reg_wdata = '0;
    logic [2:0]    reg_rsel = '0;
    logic [31:0]   reg_rdata;
    logic          cmd_write = 1'b0;
    logic          cmd_probe = 1'b0;
    logic          busy, done;
    logic [IW-1:0] ent_sel = '0;
    logic [31:0]   ent_hi, ent_mask, ent_lo0, ent_lo1;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_hi   [N];
    logic [31:0] m_mask [N];
    logic [31:0] m_lo0  [N];
    logic [31:0] m_lo1  [N];
    logic [31:0] r_hi, r_lo0, r_lo1, r_mask;
    logic [5:0]  r_idx;
    logic        r_miss;

    always #5 clk = ~clk;

    tlb_wp_ctrl #(.NUM_ENTRIES(N), .IDX_W(IW)) i_tlb_wp_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wsel(reg_wsel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .cmd_write(cmd_write), .cmd_probe(cmd_probe), .busy(busy), .done(done),
        .ent_sel(ent_sel), .ent_hi(ent_hi), .ent_mask(ent_mask),
        .ent_lo0(ent_lo0), .ent_lo1(ent_lo1)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_ehi(input logic [31:0] hi);
        return (hi & 32'hFFFF_E000) | {24'h0, hi[7:0]};
    endfunction

    function automatic logic [31:0] f_half(input logic [31:0] lo, input logic g);
        return {2'b00, lo[29:1], g};
    endfunction

    function automatic bit f_match(input int i, input logic [31:0] key);
        logic [31:0] em;
        bit g;
        em = m_mask[i] | 32'h1FFF;
        g  = m_lo0[i][0] & m_lo1[i][0];
        return ((key & ~em) == (m_hi[i] & ~em)) && (g || m_hi[i][7:0] == key[7:0]);
    endfunction

    function automatic int f_probe(input logic [31:0] key);
        for (int i = 0; i < N; i++) if (f_match(i, key)) return i;
        return -1;
    endfunction

    task automatic bus_wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        unique case (sel)
            3'd0: begin r_idx = d[5:0]; r_miss = 1'b0; end
            3'd1: r_lo0 = d & 32'h3FFF_FFFF;
            3'd2: r_lo1 = d & 32'h3FFF_FFFF;
            3'd3: r_mask = d & 32'h1FFF_E000;
            3'd4: r_hi = d & 32'hFFFF_E0FF;
            default: ;
        endcase
    endtask

    function automatic logic [31:0] f_idx();
        return {r_miss, 25'h0, r_idx};
    endfunction

    task automatic rd_reg(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_rsel = sel; #1;
        v = reg_rdata;
    endtask

    task automatic do_write();
        @(negedge clk);
        cmd_write = 1'b1;
        @(posedge clk); #1;
        cmd_write = 1'b0;
        @(posedge clk); #1;
        if (int'(r_idx) < N) begin
            m_hi[r_idx] = r_hi; m_mask[r_idx] = r_mask;
            m_lo0[r_idx] = r_lo0; m_lo1[r_idx] = r_lo1;
        end
    endtask

    task automatic chk_entry(input int i, input string req);
        logic g;
        @(negedge clk);
        ent_sel = IW'(i); #1;
        g = m_lo0[i][0] & m_lo1[i][0];
        chk(ent_hi == f_ehi(m_hi[i]), req, ent_hi, f_ehi(m_hi[i]));
        chk(ent_mask == m_mask[i], req, ent_mask, m_mask[i]);
        chk(ent_lo0 == f_half(m_lo0[i], g), req, ent_lo0, f_half(m_lo0[i], g));
        chk(ent_lo1 == f_half(m_lo1[i], g), req, ent_lo1, f_half(m_lo1[i], g));
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < N; i++) chk_entry(i, req);
    endtask

    task automatic do_probe(input string req);
        int exp_m, cyc, exp_cyc;
        logic [31:0] v;
        exp_m = f_probe(r_hi);
        @(negedge clk);
        cmd_probe = 1'b1;
        @(posedge clk); #1;
        cmd_probe = 1'b0;
        cyc = 0;
        while (!done && cyc < 3 * N) begin
            @(posedge clk); #1;
            cyc++;
        end
        exp_cyc = (exp_m < 0) ? N : exp_m + 1;
        chk(cyc == exp_cyc, "R10 latency", cyc, exp_cyc);
        @(posedge clk); #1;
        chk(!done && !busy, "R10 single pulse", {30'h0, done, busy}, 32'h0);
        if (exp_m < 0) r_miss = 1'b1;
        else begin r_miss = 1'b0; r_idx = 6'(exp_m); end
        rd_reg(3'd0, v);
        chk(v == f_idx(), req, v, f_idx());
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual %08h expected %08h", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] vpool [4];
        logic [31:0] mpool [4];
        int tmp;
        tmp = $urandom(32'd2718);
        for (int i = 0; i < N; i++) begin
            m_hi[i] = '0; m_mask[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
        end
        r_hi = '0; r_lo0 = '0; r_lo1 = '0; r_mask = '0; r_idx = '0; r_miss = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int s = 0; s < 5; s++) begin
            rd_reg(3'(s), v);
            chk(v == 32'h0, "R1 register", v, 32'h0);
        end
        chk(!busy && !done, "R1 status", {30'h0, busy, done}, 32'h0);
        chk_all("R1 entries");

        // R2 / R3 sanitising
        bus_wr(3'd3, 32'hFFFF_FFFF); rd_reg(3'd3, v);
        chk(v == 32'h1FFF_E000, "R2 page mask", v, 32'h1FFF_E000);
        bus_wr(3'd1, 32'hFFFF_FFFF); rd_reg(3'd1, v);
        chk(v == 32'h3FFF_FFFF, "R3 low word 0", v, 32'h3FFF_FFFF);
        bus_wr(3'd2, 32'hFFFF_FFFE); rd_reg(3'd2, v);
        chk(v == 32'h3FFF_FFFE, "R3 low word 1", v, 32'h3FFF_FFFE);
        bus_wr(3'd4, 32'hFFFF_FFFF); rd_reg(3'd4, v);
        chk(v == 32'hFFFF_E0FF, "R3 high word", v, 32'hFFFF_E0FF);
        bus_wr(3'd0, 32'hFFFF_FFC5); rd_reg(3'd0, v);
        chk(v == 32'h0000_0005, "R3 index", v, 32'h5);
        rd_reg(3'd6, v);
        chk(v == 32'h0, "R2 unused select", v, 32'h0);

        // R4 / R5 write with one global bit clear
        do_write();
        chk_entry(5, "R4 R5 write slot 5");

        // R5 global from both bits
        bus_wr(3'd2, 32'h1234_5679); bus_wr(3'd0, 32'd6);
        do_write();
        chk_entry(6, "R5 global set");

        // R6 out-of-range index
        bus_wr(3'd4, 32'hABCD_E001);
        bus_wr(3'd0, 32'd12); do_write();
        chk_all("R6 index 12");
        bus_wr(3'd0, 32'd63); do_write();
        chk_all("R6 index 63");

        // fill table with random but clustered contents
        vpool[0] = 32'h0040_0000; vpool[1] = 32'h0040_6000;
        vpool[2] = 32'h7FF0_0000; vpool[3] = 32'h0001_2000;
        mpool[0] = 32'h0; mpool[1] = 32'h0000_6000;
        mpool[2] = 32'h001F_E000; mpool[3] = 32'h0;
        for (int i = 0; i < N; i++) begin
            bus_wr(3'd4, vpool[$urandom % 4] | ($urandom & 32'h1F00) | 32'(1 + $urandom % 3));
            bus_wr(3'd3, mpool[$urandom % 4]);
            bus_wr(3'd1, $urandom);
            bus_wr(3'd2, (($urandom % 4) == 0) ? ($urandom | 32'h1) : ($urandom & ~32'h1));
            bus_wr(3'd0, 32'(i));
            do_write();
            chk_entry(i, "R4 R5 random write");
        end

        // directed probes: R7 mask, R8 lowest, R9 miss
        bus_wr(3'd4, 32'h0050_0002); bus_wr(3'd3, 32'h001F_E000);
        bus_wr(3'd1, 32'h2); bus_wr(3'd2, 32'h2); bus_wr(3'd0, 32'd2);
        do_write();
        bus_wr(3'd4, 32'h0040_0002); bus_wr(3'd3, 32'h0);
        bus_wr(3'd0, 32'd9); do_write();
        bus_wr(3'd4, 32'h005F_E002);
        do_probe("R7 R8 large mask");
        bus_wr(3'd4, 32'hEEEE_0077);
        do_probe("R9 miss");
        bus_wr(3'd4, 32'h0040_0002);
        do_probe("R8 lowest index");
        bus_wr(3'd4, 32'h0040_1F03);
        do_probe("R7 asid and low bits");

        // random probes
        for (int k = 0; k < 40; k++) begin
            bus_wr(3'd4, (vpool[$urandom % 4] ^ ($urandom & 32'h001F_FF00)) | 32'(1 + $urandom % 4));
            do_probe("R7 R8 R9 random probe");
        end

        // R11 activity while busy is ignored
        bus_wr(3'd4, 32'hEEEE_0077);
        @(negedge clk); cmd_probe = 1'b1;
        @(posedge clk); #1; cmd_probe = 1'b0;
        chk(busy, "R11 busy after accept", {31'h0, busy}, 32'h1);
        @(negedge clk);
        reg_we = 1'b1; reg_wsel = 3'd4; reg_wdata = 32'h0040_0001; cmd_write = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; cmd_write = 1'b0;
        while (busy) begin @(posedge clk); #1; end
        r_miss = 1'b1;
        rd_reg(3'd4, v);
        chk(v == 32'hEEEE_0077, "R11 high word kept", v, 32'hEEEE_0077);
        rd_reg(3'd0, v);
        chk(v == f_idx(), "R11 probe result", v, f_idx());
        chk_all("R11 entries kept");

        // R12 simultaneous commands
        bus_wr(3'd0, 32'd4);
        bus_wr(3'd4, 32'h0BAD_C0DE);
        @(negedge clk); cmd_write = 1'b1; cmd_probe = 1'b1;
        @(posedge clk); #1; cmd_write = 1'b0; cmd_probe = 1'b0;
        chk(busy && !done, "R12 commit cycle", {30'h0, busy, done}, 32'h2);
        @(posedge clk); #1;
        chk(!busy && !done, "R12 back to idle", {30'h0, busy, done}, 32'h0);
        m_hi[4] = r_hi; m_mask[4] = r_mask; m_lo0[4] = r_lo0; m_lo1[4] = r_lo1;
        repeat (N + 2) begin
            @(posedge clk); #1;
            chk(!done, "R12 no probe", {31'h0, done}, 32'h0);
        end
        chk_entry(4, "R12 entry written");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule